// File: doc/BRIEF.md
# Synthesizer Fastlock Timeout Controller

This block governs the fast-settling phase of a synthesizer loop that follows a new frequency setting. A 12-bit timeout word, captured on a register-load pulse, selects one of three behaviours and decides what a dedicated output pin does.

- **Disabled:** the pin is a general-purpose tri-state output. It is high impedance, driven low or driven high.
- **Manual:** fast-settling current stays on for as long as the word remains loaded.
- **Timed:** a load starts an interval that lasts a programmed number of phase-comparison strobes. During the interval the block raises the fastlock-active flag, which boosts charge-pump current, and drives the pin low.

The system clock only samples the comparison strobe. Each rising edge of the strobe advances the count by one, however many clocks the strobe stays high. Reset is asserted asynchronously and released synchronously inside the block, two clocks after the reset input rises.

Top module: `flk_timeout_ctrl`

## Requirements
- R1: While reset is active and after it is released, with no load yet seen, the pin is not driven (output enable 0) and the fastlock-active flag is 0.
- R2: After a load of word 0, the pin is high impedance (output enable 0) and fastlock-active is 0.
- R3: After a load of word 1 (manual), fastlock-active is 1 and the pin is driven to 0. Strobes do not change either while the word stays loaded.
- R4: After a load of word 2, the pin is driven to 0. After a load of word 3, the pin is driven to 1. In both cases fastlock-active is 0.
- R5: In the clock after a load of a word of 4 or more, fastlock-active is 1, output enable is 1 and the pin is 0.
- R6: An interval started with word N (N ≥ 4) ends on the clock edge that samples the N-th strobe rising edge. From the next sample on, fastlock-active is 0 and the pin is high impedance.
- R7: A strobe held high for several clocks counts as one strobe.
- R8: A load of a word of 4 or more during an active interval restarts the count from zero using the new word.
- R9: Strobes never start an interval. Only a load with a word of 4 or more does, and strobes have no effect on the outputs for words 0, 2 and 3.
- R10: When a load and a strobe rising edge fall in the same clock, the load wins and that strobe is not counted.
- R11: Word 4095 keeps fastlock-active on for exactly 4095 strobes.
- R12: Changes of the timeout word without a load pulse have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_strobe_i | input | 1 | Phase-comparison strobe. Its rising edge counts one cycle |
| load_i | input | 1 | One-clock pulse that captures the timeout word |
| toc_word_i | input | 12 | Timeout word: 0 high-Z pin, 1 manual, 2 pin low, 3 pin high, 4..4095 timed count |
| pin_o | output | 1 | Data value of the dedicated pin |
| pin_oe_o | output | 1 | Output enable of the dedicated pin. 0 means high impedance |
| fast_active_o | output | 1 | Fastlock active: raises charge-pump current |

## Verification
The hardest case to reach is a strobe rising edge that coincides with a load. The block must let the restart win and must not count that strobe. Reaching it takes a reload issued with the strobe already high, while the strobe was low in the previous clock. The stimulus builds this case and then counts the remaining strobes, so a design that counted the coinciding edge would end the interval one strobe early. Restart during an interval is exposed in a similar way. The second word is loaded after several strobes, and the bench checks that the interval outlasts the first word's count.

// File: rtl/flk_pkg.sv
package flk_pkg;

  typedef enum logic [2:0] {
    FLK_HIZ    = 3'd0,
    FLK_MANUAL = 3'd1,
    FLK_DRV0   = 3'd2,
    FLK_DRV1   = 3'd3,
    FLK_TIMED  = 3'd4
  } flk_mode_e;

  localparam int unsigned FLK_TIMED_MIN = 4;

  function automatic flk_mode_e flk_classify(input logic [11:0] word);
    flk_mode_e m;
    if (word >= 12'(FLK_TIMED_MIN)) m = FLK_TIMED;
    else begin
      unique case (word[1:0])
        2'd0:    m = FLK_HIZ;
        2'd1:    m = FLK_MANUAL;
        2'd2:    m = FLK_DRV0;
        default: m = FLK_DRV1;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/flk_rst_sync.sv
module flk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/flk_edge_det.sv
module flk_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);

  logic strobe_q;
  logic strobe_d;

  always_comb begin
    strobe_d = strobe_i;
    rise_o   = strobe_i & ~strobe_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_d;
  end

endmodule

// File: rtl/flk_timer.sv
module flk_timer #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] limit_i,
  output logic              busy_o
);

  logic [WORD_W-1:0] cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              cnt_en;
  logic [WORD_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt_q + WORD_W'(1);
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    cnt_en  = 1'b0;
    if (start_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (stop_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (busy_q && tick_i) begin
      cnt_en = 1'b1;
      if (cnt_inc == limit_i) begin
        cnt_d  = '0;
        busy_d = 1'b0;
      end else begin
        cnt_d  = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/flk_pin_mux.sv
module flk_pin_mux
  import flk_pkg::*;
(
  input  flk_mode_e mode_i,
  input  logic      timed_busy_i,
  output logic      pin_o,
  output logic      pin_oe_o,
  output logic      fast_o
);

  always_comb begin
    pin_o    = 1'b0;
    pin_oe_o = 1'b0;
    fast_o   = 1'b0;
    unique case (mode_i)
      FLK_HIZ: ;
      FLK_MANUAL: begin
        pin_oe_o = 1'b1;
        fast_o   = 1'b1;
      end
      FLK_DRV0: pin_oe_o = 1'b1;
      FLK_DRV1: begin
        pin_oe_o = 1'b1;
        pin_o    = 1'b1;
      end
      FLK_TIMED: begin
        pin_oe_o = timed_busy_i;
        fast_o   = timed_busy_i;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flk_timeout_ctrl.sv
module flk_timeout_ctrl
  import flk_pkg::*;
#(
  parameter int unsigned WORD_W     = 12,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_strobe_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] toc_word_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              fast_active_o
);

  localparam logic [WORD_W-1:0] TIMED_MIN = WORD_W'(FLK_TIMED_MIN);

  logic              rst_sync_n;
  logic              strobe_rise;
  logic [WORD_W-1:0] word_q, word_d;
  logic              word_en;
  logic              start_timed;
  logic              stop_timed;
  logic              timed_busy;
  flk_mode_e         mode;

  flk_rst_sync #(.STAGES(SYNC_DEPTH)) i_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  flk_edge_det i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .strobe_i(cmp_strobe_i),
    .rise_o  (strobe_rise)
  );

  always_comb begin
    word_en     = load_i;
    word_d      = toc_word_i;
    start_timed = load_i && (toc_word_i >= TIMED_MIN);
    stop_timed  = load_i && (toc_word_i <  TIMED_MIN);
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  always_comb begin
    if (word_q >= TIMED_MIN) mode = FLK_TIMED;
    else                     mode = flk_classify(12'(word_q[1:0]));
  end

  flk_timer #(.WORD_W(WORD_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .start_i(start_timed),
    .stop_i (stop_timed),
    .tick_i (strobe_rise),
    .limit_i(word_q),
    .busy_o (timed_busy)
  );

  flk_pin_mux i_mux (
    .mode_i      (mode),
    .timed_busy_i(timed_busy),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe_o),
    .fast_o      (fast_active_o)
  );

endmodule

// File: rtl/flk_timeout_chk.sv
module flk_timeout_chk #(
  parameter int unsigned WORD_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmp_strobe_i,
  input logic              load_i,
  input logic [WORD_W-1:0] toc_word_i,
  input logic              pin_o,
  input logic              pin_oe_o,
  input logic              fast_active_o
);

  localparam logic [WORD_W-1:0] MIN_T = WORD_W'(4);

  AST_TIMED_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && toc_word_i >= MIN_T) |=> (fast_active_o && pin_oe_o && !pin_o)); // R5

  AST_CODE0_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && toc_word_i == '0) |=> (!pin_oe_o && !fast_active_o)); // R2

  AST_MANUAL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && toc_word_i == WORD_W'(1)) |=> (fast_active_o && pin_oe_o && !pin_o)); // R3

  AST_DRIVE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && toc_word_i == WORD_W'(3)) |=> (pin_oe_o && pin_o && !fast_active_o)); // R4

  AST_NO_STROBE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !$rose(fast_active_o)); // R9

  AST_WORD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cmp_strobe_i) |=> ($stable(pin_o) && $stable(pin_oe_o) && $stable(fast_active_o))); // R12

endmodule

bind flk_timeout_ctrl flk_timeout_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_sync_n),
  .cmp_strobe_i (cmp_strobe_i),
  .load_i       (load_i),
  .toc_word_i   (toc_word_i),
  .pin_o        (pin_o),
  .pin_oe_o     (pin_oe_o),
  .fast_active_o(fast_active_o)
);

// File: tb/test_flk_timeout_ctrl.sv
`timescale 1ns/1ps
module test_flk_timeout_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe;
  logic        load;
  logic [11:0] word;
  logic        pin, oe, act;

  typedef struct {
    logic  pin;
    logic  oe;
    logic  act;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #2 clk = ~clk;

  flk_timeout_ctrl i_flk_timeout_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmp_strobe_i (strobe),
    .load_i       (load),
    .toc_word_i   (word),
    .pin_o        (pin),
    .pin_oe_o     (oe),
    .fast_active_o(act)
  );

  // driver: applies one clock of stimulus, then queues the expected outputs
  task automatic drive(input logic ld, input logic [11:0] w, input logic st,
                       input logic ep, input logic eo, input logic ea, input string tag);
    exp_t e;
    @(negedge clk);
    load = ld; word = w; strobe = st;
    @(posedge clk);
    #1;
    e.pin = ep; e.oe = eo; e.act = ea; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // one strobe pulse: hi clocks high, one low; timed interval active until ends
  task automatic pulse(input int hi, input bit ends, input string tag);
    for (int k = 0; k < hi; k++)
      drive(1'b0, 12'hA5C, 1'b1, 1'b0, !ends, !ends, tag);
    drive(1'b0, 12'h001, 1'b0, 1'b0, !ends, !ends, tag);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      n_tests++;
      if (oe !== e.oe || act !== e.act || (e.oe && pin !== e.pin)) begin
        n_fail++;
        $display("FAIL %s: got pin=%b oe=%b act=%b expected pin=%b oe=%b act=%b",
                 e.tag, pin, oe, act, e.pin, e.oe, e.act);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load = 1'b0; word = '0; strobe = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if (oe !== 1'b0 || act !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got oe=%b act=%b expected oe=0 act=0", oe, act);
    end
    @(negedge clk) rst_n = 1'b1;
    repeat (3) drive(1'b0, 12'h7FF, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

    // R2: high impedance
    drive(1'b1, 12'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    pulse(1, 1'b1, "R2");

    // R3: manual stays on through strobes
    drive(1'b1, 12'd1, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, 12'h9, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
      drive(1'b0, 12'h9, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
    end

    // R4 / R9: drive low and high, strobes ignored
    drive(1'b1, 12'd2, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
    drive(1'b0, 12'd3, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
    drive(1'b1, 12'd3, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
    drive(1'b0, 12'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
    drive(1'b0, 12'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R12");

    // R5 / R6: word 5 lasts five strobes
    drive(1'b1, 12'd5, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
    for (int i = 1; i <= 5; i++) pulse(1, i == 5, "R6");
    pulse(1, 1'b1, "R9");

    // R7: long strobes count once each
    drive(1'b1, 12'd4, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
    for (int i = 1; i <= 4; i++) pulse(3, i == 4, "R7");

    // R8: restart with new word mid-interval
    drive(1'b1, 12'd6, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 3; i++) pulse(1, 1'b0, "R8");
    drive(1'b1, 12'd4, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    for (int i = 1; i <= 4; i++) pulse(1, i == 4, "R8");

    // R10: load and strobe edge together, edge not counted
    drive(1'b1, 12'd5, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
    drive(1'b0, 12'd5, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
    drive(1'b0, 12'd5, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
    for (int i = 1; i <= 5; i++) pulse(1, i == 5, "R10");

    // R9 / R12: strobes and word changes after the end
    for (int i = 0; i < 3; i++) pulse(1, 1'b1, "R12");

    // R11: longest interval
    drive(1'b1, 12'd4095, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
    for (int i = 1; i <= 4095; i++) pulse(1, i == 4095, "R11");

    wait (exp_q.size() == 0);
    #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule